// File: doc/BRIEF.md
# Synchronous Burst SRAM with Byte-Lane Writes

This block is a synthesizable model of a pipelined synchronous burst SRAM. It holds a word of four 9-bit lanes, each lane being eight data bits and one parity bit. An access starts when one of two address strobes loads an external address. The strobe driven by the processor always starts a read. The strobe driven by the cache controller starts a read or a write, chosen by the write-control inputs. The next accesses of the burst come from a two-bit counter that a burst-advance input steps. When that input is not asserted, the burst holds at the current word. The two low address bits follow either a linear order or an interleaved order.

Three chip selects decide whether the device takes part. They are sampled only on an edge that loads a new address. The tri-state data bus is split into separate input, output and drive-enable signals. The output enable and a sleep input gate the drive without waiting for a clock. The sleep input also stops all operations, and operations stay stopped for a fixed number of clock cycles after sleep is released. The array depth is a parameter.

Top module: `burst_sram`

## Requirements
- R1: An edge that loads an address selects the device only when `sel_a_ni` is low, `sel_b_i` is high and `sel_c_ni` is low. Any other combination on a loading edge ends the burst, writes nothing and leaves the data bus undriven.
- R2: When `sel_a_ni` is low, a low `ads_cpu_ni` starts a read burst at `addr_i` whatever the write controls say. When `sel_a_ni` is high, `ads_cpu_ni` is ignored and `ads_ctl_ni` is examined instead.
- R3: A low `ads_ctl_ni` on a selected edge starts a burst at `addr_i`. That burst is a write or a read according to the write decode of R4.
- R4: Write decode works as follows. A low `gwe_ni` writes all four lanes. Otherwise, a low `bwe_ni` writes the lanes k whose bit k of `lane_we_ni` is low, where lane k is data bits [9k+8:9k]. Every other combination, including `bwe_ni` low with all lane bits high, is a read.
- R5: On an edge with neither strobe active and a burst running, a low `adv_ni` steps to the next burst address and a high `adv_ni` stays on the current one. The access on that edge, read or write, uses the resulting address.
- R6: The two low address bits are the start bits XOR the count when `interleave_i` is high, and the start bits plus the count modulo 4 when it is low. The upper bits stay fixed, and the sequence wraps after four accesses.
- R7: Read data is registered and appears after the edge that performs the read. After a write edge the bus is not driven.
- R8: A high `oe_ni` turns `dq_oe_o` off at once, without a clock edge. Lowering `oe_ni` again restores the held read data.
- R9: A high `sleep_i` turns `dq_oe_o` off at once and blocks every operation while the stored contents are kept. After `sleep_i` falls, the first two clock edges are ignored and the third edge operates.
- R10: `adv_ni` has no effect on an edge that loads a new address.
- R11: After reset the bus is not driven and no burst is running, so an advance without a strobe performs no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Active-low reset |
| addr_i | input | AW | External word address |
| sel_a_ni | input | 1 | Primary chip select, active low; also gates the processor strobe |
| sel_b_i | input | 1 | Second chip select, active high |
| sel_c_ni | input | 1 | Third chip select, active low |
| ads_cpu_ni | input | 1 | Processor address strobe, active low |
| ads_ctl_ni | input | 1 | Controller address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| gwe_ni | input | 1 | Global write, active low |
| bwe_ni | input | 1 | Byte-write enable, active low |
| lane_we_ni | input | LANES | Per-lane write enables, active low |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| interleave_i | input | 1 | Burst order: 1 interleaved, 0 linear |
| sleep_i | input | 1 | Power-down request, active high |
| dq_i | input | LANES*LANE_W | Write data |
| dq_o | output | LANES*LANE_W | Read data |
| dq_oe_o | output | 1 | Data bus drive enable |

## Verification
Two pairs of functions can fall in the same cycle. On an edge where a strobe loads a new address, the burst advance also arrives. A read is pending on the bus when the output enable or the sleep input changes between edges. The bench drives `adv_ni` low on a processor-strobe edge and expects the word at the loaded address, not the next one. It also toggles `oe_ni` and `sleep_i` part-way through a cycle and samples `dq_oe_o` before the next edge, expecting the drive to turn off and come back with unchanged data. The wake-up delay is checked by attempting writes on each edge after sleep is released and reading back which ones took effect.

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int LANES      = 4,
  parameter int LANE_W     = 9,
  parameter int DEPTH      = 256,
  parameter int BURST_BITS = 2,
  parameter int WAKE       = 2,
  localparam int W  = LANES * LANE_W,
  localparam int AW = $clog2(DEPTH),
  localparam int WW = $clog2(WAKE + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic             sel_a_ni,
  input  logic             sel_b_i,
  input  logic             sel_c_ni,
  input  logic             ads_cpu_ni,
  input  logic             ads_ctl_ni,
  input  logic             adv_ni,
  input  logic             gwe_ni,
  input  logic             bwe_ni,
  input  logic [LANES-1:0] lane_we_ni,
  input  logic             oe_ni,
  input  logic             interleave_i,
  input  logic             sleep_i,
  input  logic [W-1:0]     dq_i,
  output logic [W-1:0]     dq_o,
  output logic             dq_oe_o
);
  localparam int BB = BURST_BITS;

  logic [W-1:0]     mem [DEPTH];
  logic [W-1:0]     rd_q;
  logic             rd_vld_q;
  logic             burst_q;
  logic [AW-1:0]    base_q;
  logic [BB-1:0]    cnt_q;
  logic [WW-1:0]    wake_cnt;

  function automatic logic [BB-1:0] order_f(input logic [BB-1:0] b,
                                            input logic [BB-1:0] k,
                                            input logic il);
    return il ? (b ^ k) : (b + k);
  endfunction

  wire awake   = !sleep_i && (wake_cnt == '0);
  wire proc_go = !ads_cpu_ni && !sel_a_ni;
  wire ctrl_go = !proc_go && !ads_ctl_ni;
  wire load    = proc_go || ctrl_go;
  wire sel_ok  = !sel_a_ni && sel_b_i && !sel_c_ni;
  wire wr_req  = !gwe_ni || (!bwe_ni && !(&lane_we_ni));

  logic [LANES-1:0] lane_mask;
  assign lane_mask = !gwe_ni ? {LANES{1'b1}} : (!bwe_ni ? ~lane_we_ni : '0);

  wire [BB-1:0] step = cnt_q + {{(BB-1){1'b0}}, !adv_ni};

  logic [AW-1:0] acc_addr;
  assign acc_addr = load ? addr_i
                         : {base_q[AW-1:BB], order_f(base_q[BB-1:0], step, interleave_i)};

  wire do_op = awake && (load ? sel_ok : burst_q);
  wire do_wr = do_op && (load ? (ctrl_go && wr_req) : wr_req);
  wire do_rd = do_op && !do_wr;

  logic [LANES-1:0] we_mask;
  assign we_mask = do_wr ? lane_mask : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      burst_q  <= 1'b0;
      base_q   <= '0;
      cnt_q    <= '0;
      wake_cnt <= '0;
      rd_vld_q <= 1'b0;
    end else if (sleep_i) begin
      wake_cnt <= WW'(WAKE);
      rd_vld_q <= 1'b0;
    end else if (wake_cnt != '0) begin
      wake_cnt <= wake_cnt - 1'b1;
      rd_vld_q <= 1'b0;
    end else begin
      if (load) begin
        burst_q <= sel_ok;
        base_q  <= addr_i;
        cnt_q   <= '0;
      end else if (burst_q) begin
        cnt_q <= step;
      end
      rd_vld_q <= do_rd;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_rd) rd_q <= mem[acc_addr];
    for (int k = 0; k < LANES; k++)
      if (we_mask[k]) mem[acc_addr][k*LANE_W +: LANE_W] <= dq_i[k*LANE_W +: LANE_W];
  end

  assign dq_o    = rd_q;
  assign dq_oe_o = rd_vld_q && !oe_ni && !sleep_i;

  // R1
  desel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (awake && load && !sel_ok) |=> (!rd_vld_q && !burst_q));
  // R2
  proc_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (awake && proc_go && sel_ok) |-> (we_mask == '0));
  // R4
  global_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gwe_ni && do_op && !proc_go) |-> (&we_mask));
  // R5
  adv_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (awake && !load && burst_q && !adv_ni) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R7
  write_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_wr |=> !dq_oe_o);
  // R9
  wake_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_cnt != '0) |-> (we_mask == '0));
endmodule

// File: tb/burst_sram_tb.sv
module burst_sram_tb_top;
  localparam int W = 36;
  logic clk_i = 0, rst_ni = 0;
  logic [7:0] addr_i = '0;
  logic sel_a_ni = 0, sel_b_i = 1, sel_c_ni = 0;
  logic ads_cpu_ni = 1, ads_ctl_ni = 1, adv_ni = 1;
  logic gwe_ni = 1, bwe_ni = 1;
  logic [3:0] lane_we_ni = 4'hF;
  logic oe_ni = 0, interleave_i = 0, sleep_i = 0;
  logic [W-1:0] dq_i = '0;
  logic [W-1:0] dq_o;
  logic dq_oe_o;
  logic [W-1:0] ref_mem [256];
  int checks = 0, fails = 0;

  always #2.5 clk_i = ~clk_i;

  burst_sram dut_i (.*);

  function automatic logic [W-1:0] pat(logic [7:0] a, logic [3:0] s);
    return {s, a, a ^ 8'h5A, ~a, a + 8'h33};
  endfunction

  function automatic logic [7:0] baddr(logic [7:0] s, int k, logic il);
    logic [1:0] lo;
    lo = il ? (s[1:0] ^ 2'(k)) : (s[1:0] + 2'(k));
    return {s[7:2], lo};
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk_i); #1;
  endtask

  task automatic idle();
    ads_cpu_ni = 1; ads_ctl_ni = 1; adv_ni = 1;
    gwe_ni = 1; bwe_ni = 1; lane_we_ni = 4'hF;
    sel_a_ni = 0; sel_b_i = 1; sel_c_ni = 0;
  endtask

  function automatic logic [3:0] decode(logic gw, logic bw, logic [3:0] lw);
    return !gw ? 4'hF : (!bw ? ~lw : 4'h0);
  endfunction

  task automatic upd(logic [7:0] a, logic [W-1:0] d, logic [3:0] m);
    for (int k = 0; k < 4; k++)
      if (m[k]) ref_mem[a][k*9 +: 9] = d[k*9 +: 9];
  endtask

  task automatic ctl_op(logic [7:0] a, logic [W-1:0] d, logic gw, logic bw, logic [3:0] lw);
    idle(); addr_i = a; ads_ctl_ni = 0; gwe_ni = gw; bwe_ni = bw; lane_we_ni = lw; dq_i = d;
    cyc();
    upd(a, d, decode(gw, bw, lw));
    idle();
  endtask

  task automatic rd(logic [7:0] a, string tag);
    idle(); addr_i = a; ads_cpu_ni = 0; cyc(); idle();
    chk({tag, " drive"}, dq_oe_o, 1);
    chk({tag, " data"}, dq_o, ref_mem[a]);
  endtask

  task automatic t_reset();
    chk("R11 reset drive", dq_oe_o, 0);
    idle(); adv_ni = 0; cyc(); idle();
    chk("R11 advance without burst", dq_oe_o, 0);
  endtask

  task automatic t_linear_burst();
    interleave_i = 0;
    ctl_op(8'h10, pat(8'h10, 1), 0, 1, 4'hF);
    chk("R7 write leaves bus idle", dq_oe_o, 0);
    for (int k = 1; k < 4; k++) begin
      adv_ni = 0; gwe_ni = 0; dq_i = pat(8'h10 + 8'(k), 1); cyc();
      upd(8'h10 + 8'(k), pat(8'h10 + 8'(k), 1), 4'hF);
    end
    idle();
    addr_i = 8'h11; ads_cpu_ni = 0; cyc(); idle();
    chk("R2 R7 linear first", dq_o, ref_mem[8'h11]);
    for (int k = 1; k < 5; k++) begin
      adv_ni = 0; cyc();
      chk("R5 R6 linear step", dq_o, ref_mem[baddr(8'h11, k, 0)]);
    end
    idle();
  endtask

  task automatic t_interleave();
    interleave_i = 1;
    ctl_op(8'h22, pat(8'h22, 2), 0, 1, 4'hF);
    for (int k = 1; k < 4; k++) begin
      adv_ni = 0; gwe_ni = 0; dq_i = pat(baddr(8'h22, k, 1), 2); cyc();
      upd(baddr(8'h22, k, 1), pat(baddr(8'h22, k, 1), 2), 4'hF);
    end
    idle();
    addr_i = 8'h22; ads_cpu_ni = 0; adv_ni = 0; cyc(); idle();
    chk("R10 advance on strobe edge ignored", dq_o, ref_mem[8'h22]);
    for (int k = 1; k < 5; k++) begin
      adv_ni = 0; cyc();
      chk("R6 interleaved step", dq_o, ref_mem[baddr(8'h22, k, 1)]);
    end
    idle();
    interleave_i = 0;
  endtask

  task automatic t_bytes();
    ctl_op(8'h70, pat(8'h70, 1), 0, 1, 4'hF);
    ctl_op(8'h70, pat(8'h70, 2), 1, 0, 4'b1010);
    rd(8'h70, "R4 lanes 0 and 2");
    idle(); addr_i = 8'h70; ads_ctl_ni = 0; lane_we_ni = 4'h0; dq_i = '1; cyc(); idle();
    chk("R3 R4 no enables is read drive", dq_oe_o, 1);
    chk("R3 R4 no enables is read data", dq_o, ref_mem[8'h70]);
    ctl_op(8'h70, '1, 1, 0, 4'hF);
    chk("R4 lanes all high is read", dq_o, ref_mem[8'h70]);
    ctl_op(8'h70, pat(8'h70, 3), 0, 1, 4'hF);
    rd(8'h70, "R4 global write");
  endtask

  task automatic t_proc_ignores_write();
    idle(); addr_i = 8'h10; ads_cpu_ni = 0; gwe_ni = 0; dq_i = '0; cyc(); idle();
    chk("R2 processor strobe reads", dq_o, ref_mem[8'h10]);
    rd(8'h10, "R2 memory unchanged");
  endtask

  task automatic t_deselect();
    for (int k = 0; k < 3; k++) ctl_op(8'h50 + 8'(k), pat(8'h50 + 8'(k), 5), 0, 1, 4'hF);
    for (int k = 0; k < 3; k++) begin
      idle(); addr_i = 8'h50 + 8'(k); ads_ctl_ni = 0; gwe_ni = 0; dq_i = '0;
      if (k == 0) sel_a_ni = 1;
      if (k == 1) sel_b_i = 0;
      if (k == 2) sel_c_ni = 1;
      cyc(); idle();
      chk("R1 deselected drive", dq_oe_o, 0);
    end
    idle(); sel_a_ni = 1; ads_cpu_ni = 0; addr_i = 8'h50; cyc(); idle();
    chk("R2 processor strobe blocked", dq_oe_o, 0);
    for (int k = 0; k < 3; k++) rd(8'h50 + 8'(k), "R1 no write when deselected");
  endtask

  task automatic t_suspend();
    idle(); addr_i = 8'h20; ads_cpu_ni = 0; cyc(); idle();
    adv_ni = 0; cyc();
    chk("R5 advance", dq_o, ref_mem[8'h21]);
    adv_ni = 1; cyc();
    chk("R5 suspend read", dq_o, ref_mem[8'h21]);
    adv_ni = 0; cyc(); idle();
    chk("R5 resume", dq_o, ref_mem[8'h22]);
    ctl_op(8'h60, pat(8'h60, 6), 0, 1, 4'hF);
    adv_ni = 0; gwe_ni = 0; dq_i = pat(8'h61, 6); cyc(); upd(8'h61, pat(8'h61, 6), 4'hF);
    adv_ni = 1; gwe_ni = 0; dq_i = pat(8'h61, 7); cyc(); upd(8'h61, pat(8'h61, 7), 4'hF);
    idle();
    rd(8'h60, "R5 write start");
    rd(8'h61, "R5 suspend write");
  endtask

  task automatic t_oe();
    rd(8'h11, "R8 setup");
    oe_ni = 1; #1;
    chk("R8 oe off", dq_oe_o, 0);
    oe_ni = 0; #1;
    chk("R8 oe back", dq_oe_o, 1);
    chk("R8 data held", dq_o, ref_mem[8'h11]);
  endtask

  task automatic t_sleep();
    for (int k = 0; k < 4; k++) ctl_op(8'h40 + 8'(k), pat(8'h40 + 8'(k), 8), 0, 1, 4'hF);
    rd(8'h40, "R9 setup");
    sleep_i = 1; #1;
    chk("R9 sleep drive off", dq_oe_o, 0);
    idle(); addr_i = 8'h40; ads_ctl_ni = 0; gwe_ni = 0; dq_i = '0; cyc();
    sleep_i = 0;
    addr_i = 8'h41; cyc();
    addr_i = 8'h42; cyc();
    addr_i = 8'h43; cyc(); upd(8'h43, '0, 4'hF);
    idle();
    for (int k = 0; k < 4; k++) rd(8'h40 + 8'(k), "R9 wake delay");
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    #1;
    t_reset();
    t_linear_burst();
    t_interleave();
    t_bytes();
    t_proc_ignores_write();
    t_deselect();
    t_suspend();
    t_oe();
    t_sleep();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule